// File: doc/BRIEF.md
# Programmable-Priority IRQ/FIQ Interrupt Controller

This block collects level-sensitive requests from 23 internal peripheral lines and 6 external pins and presents them to a processor as two request outputs: a normal request (IRQ) and a fast request (FIQ). Each source has a mask bit and a routing bit that selects which output it feeds. A global mask bit shuts off both outputs at once. External pins pass through a two-flop synchroniser; internal lines are used directly.

Priority is held in a table of 39 rank slots. Software writes a source number into a slot, and the source takes that slot's rank. Slot 0 outranks every other slot. For each output, the block finds the pending, enabled source in the best-ranked slot and reports its number through a read-only register. Software uses this result to pick the handler. The register port is a simple synchronous word-addressed port with a 32-bit data path.

Sources are numbered 0 to 22 for internal lines (`int_src_i[i]` is source i) and 23 to 28 for external pins (`ext_src_i[j]` is source 23+j).

Top module: `intc_core`

## Requirements
- R1: After reset, irq_o and fiq_o are 0. Reads return 0x007F_FFFF from address 2, 0x8000_003F from address 3, and 0 from addresses 0 and 1. Reads from addresses 4 and 5 return 0x3F. Slot s holds s for s < 29 and 0x3F for the slots above.
- R2: When bit 31 of address 3 (the global mask) is 1, irq_o and fiq_o are 0 and both winner registers read 0x3F, whatever the sources and the other settings are.
- R3: A source whose mask bit is 1 never drives an output and never wins. Address 2 bit i holds the mask for internal source i. Address 3 bit j holds the mask for external source 23+j.
- R4: A source whose routing bit is 0 feeds only IRQ, and one whose routing bit is 1 feeds only FIQ. Address 0 bit i holds the routing bit for internal source i. Address 1 bit j holds the routing bit for external source 23+j.
- R5: Requests are level sensitive. An output stays high only while at least one enabled source routed to it is held active, and it falls once the line is released.
- R6: An internal line affects irq_o/fiq_o in the same cycle. An external pin affects them two rising clock edges after it changes.
- R7: Addresses 8 to 17 hold the slot table. In address 8+n, bits [8k+5:8k] hold slot 4n+k, and a field beyond slot 38 is not stored. Slot 0 has the highest rank.
- R8: The winner is the source number in the lowest-numbered slot whose source is pending, enabled and routed to that output. When a number sits in several slots, its best slot counts. A slot holding 29 or more is skipped.
- R9: Address 4 returns the IRQ winner and address 5 returns the FIQ winner, in bits [5:0]. Each reads 0x3F when no pending, enabled source routed to that output sits in any slot. This includes the case where the output is high from a source that has no slot.
- R10: Writes take effect at the clock edge where we_i is high. rdata_o is loaded at the edge where re_i is high and shows the state held before that edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_src_i | input | 23 | Internal request lines, active high |
| ext_src_i | input | 6 | External request pins, active high, asynchronous |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is a slot table that holds duplicate numbers, out-of-range numbers and sources with no slot, while both outputs have competing requests. Only that state shows whether rank resolution picks the best slot and skips bad entries. Random slot writes draw field values from the whole 6-bit range, so duplicates and numbers of 29 or more are common. A directed case then sets up an output that is high while its winner register reads 0x3F. External pins are changed only ahead of a settle window that covers the synchroniser delay, and one directed case counts that delay edge by edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_INT     = 23;
  localparam int N_EXT     = 6;
  localparam int N_SLOT    = 39;
  localparam int IDX_W     = 6;
  localparam int AW        = 5;
  localparam int A_MODE_I  = 0;
  localparam int A_MODE_E  = 1;
  localparam int A_MASK_I  = 2;
  localparam int A_MASK_E  = 3;
  localparam int A_WIN_IRQ = 4;
  localparam int A_WIN_FIQ = 5;
  localparam int A_PRIO    = 8;
  localparam int GMASK_BIT = 31;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N_SRC  = 29,
  parameter int N_SLOT = 39,
  parameter int IDX_W  = 6
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SLOT*IDX_W-1:0] slots_i,
  output logic [IDX_W-1:0]        win_o
);
  localparam int SPACE = 1 << IDX_W;
  logic [SPACE-1:0] req_w;
  assign req_w = {{(SPACE-N_SRC){1'b0}}, req_i};

  // scan from worst rank up so the best slot overwrites; numbers >= N_SRC hit zero padding
  always_comb begin
    win_o = '1;
    for (int s = N_SLOT-1; s >= 0; s--) begin
      if (req_w[slots_i[s*IDX_W +: IDX_W]]) win_o = slots_i[s*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = N_INT + N_EXT
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [IDX_W-1:0]        irq_win_i,
  input  logic [IDX_W-1:0]        fiq_win_i,
  output logic [31:0]             rdata_o,
  output logic [N_SRC-1:0]        mode_o,
  output logic [N_SRC-1:0]        mask_o,
  output logic                    gmask_o,
  output logic [N_SLOT*IDX_W-1:0] slots_o
);
  logic [N_SRC-1:0] mode_q, mask_q;
  logic             gmask_q;
  logic [IDX_W-1:0] slot_q [N_SLOT];
  logic [31:0]      rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      mask_q  <= '1;
      gmask_q <= 1'b1;
      for (int s = 0; s < N_SLOT; s++)
        slot_q[s] <= (s < N_SRC) ? IDX_W'(s) : '1;
    end else if (we_i) begin
      case (addr_i)
        AW'(A_MODE_I): mode_q[N_INT-1:0]     <= wdata_i[N_INT-1:0];
        AW'(A_MODE_E): mode_q[N_SRC-1:N_INT] <= wdata_i[N_EXT-1:0];
        AW'(A_MASK_I): mask_q[N_INT-1:0]     <= wdata_i[N_INT-1:0];
        AW'(A_MASK_E): begin
          mask_q[N_SRC-1:N_INT] <= wdata_i[N_EXT-1:0];
          gmask_q               <= wdata_i[GMASK_BIT];
        end
        default: ;
      endcase
      for (int s = 0; s < N_SLOT; s++)
        if (addr_i == AW'(A_PRIO + s/4)) slot_q[s] <= wdata_i[8*(s%4) +: IDX_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(A_MODE_I):  rd_mux[N_INT-1:0] = mode_q[N_INT-1:0];
      AW'(A_MODE_E):  rd_mux[N_EXT-1:0] = mode_q[N_SRC-1:N_INT];
      AW'(A_MASK_I):  rd_mux[N_INT-1:0] = mask_q[N_INT-1:0];
      AW'(A_MASK_E): begin
        rd_mux[N_EXT-1:0] = mask_q[N_SRC-1:N_INT];
        rd_mux[GMASK_BIT] = gmask_q;
      end
      AW'(A_WIN_IRQ): rd_mux[IDX_W-1:0] = irq_win_i;
      AW'(A_WIN_FIQ): rd_mux[IDX_W-1:0] = fiq_win_i;
      default: ;
    endcase
    for (int s = 0; s < N_SLOT; s++)
      if (addr_i == AW'(A_PRIO + s/4)) rd_mux[8*(s%4) +: IDX_W] = slot_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_flat
    assign slots_o[s*IDX_W +: IDX_W] = slot_q[s];
  end

  assign mode_o  = mode_q;
  assign mask_o  = mask_q;
  assign gmask_o = gmask_q;
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int N_SRC = N_INT + N_EXT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INT-1:0]  int_src_i,
  input  logic [N_EXT-1:0]  ext_src_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_EXT-1:0]          ext_pend;
  logic [N_SRC-1:0]          pend, en, mode, mask;
  logic                      gmask;
  logic [N_SLOT*IDX_W-1:0]   slots;
  logic [1:0][N_SRC-1:0]     req_by;
  logic [1:0][IDX_W-1:0]     win_by;
  logic [IDX_W-1:0]          irq_win, fiq_win;

  intc_sync #(.W(N_EXT)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_src_i), .q_o(ext_pend)
  );

  assign pend = {ext_pend, int_src_i};
  assign en   = pend & ~mask & {N_SRC{~gmask}};
  assign req_by[0] = en & ~mode;
  assign req_by[1] = en & mode;

  // index 0 serves IRQ, index 1 serves FIQ
  for (genvar g = 0; g < 2; g++) begin : g_arb
    intc_arb #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .IDX_W(IDX_W)) u_arb (
      .req_i(req_by[g]), .slots_i(slots), .win_o(win_by[g])
    );
  end

  assign irq_win = win_by[0];
  assign fiq_win = win_by[1];
  assign irq_o   = |req_by[0];
  assign fiq_o   = |req_by[1];

  intc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .irq_win_i(irq_win), .fiq_win_i(fiq_win),
    .rdata_o(rdata_o), .mode_o(mode), .mask_o(mask), .gmask_o(gmask), .slots_o(slots)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int N_SRC = N_INT + N_EXT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EXT-1:0] ext_src_i,
  input logic [N_EXT-1:0] ext_pend,
  input logic [N_SRC-1:0] mask,
  input logic             gmask,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [IDX_W-1:0] irq_win,
  input logic [IDX_W-1:0] fiq_win
);
  localparam logic [IDX_W-1:0] NONE = '1;
  logic [1:0] cnt;
  logic [63:0] mask_w;
  assign mask_w = {{(64-N_SRC){1'b0}}, mask};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  // R2
  gmask_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask |-> (!irq_o && !fiq_o && irq_win == NONE && fiq_win == NONE));
  // R4
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_win != NONE) |-> (irq_win != fiq_win));
  // R9
  irq_win_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_win != NONE) |-> irq_o);
  // R9
  fiq_win_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_win != NONE) |-> fiq_o);
  // R8
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_win == NONE || int'(irq_win) < N_SRC) && (fiq_win == NONE || int'(fiq_win) < N_SRC));
  // R3
  win_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_win != NONE) |-> !mask_w[irq_win]);
  // R6
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt >= 2'd2) |-> (ext_pend == $past(ext_src_i, 2)));
endmodule

bind intc_core intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_src_i(ext_src_i), .ext_pend(ext_pend),
  .mask(mask), .gmask(gmask), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_win(irq_win), .fiq_win(fiq_win)
);

// File: tb/intc_core_test.sv
`timescale 1ns/1ps
module intc_core_test;
  localparam int NS = 29, NI = 23, NE = 6, NSL = 39;

  logic        clk_i = 0, rst_ni = 0;
  logic [22:0] int_src_i = '0;
  logic [5:0]  ext_src_i = '0;
  logic        we_i = 0, re_i = 0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;
  bit m_mode[NS], m_mask[NS], m_g;
  int m_slot[NSL];

  intc_core uut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog: run hung, act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i); we_i = 1; addr_i = 5'(a); wdata_i = d;
    @(negedge clk_i); we_i = 0;
    if (a == 0) for (int i = 0; i < NI; i++) m_mode[i] = d[i];
    if (a == 1) for (int j = 0; j < NE; j++) m_mode[NI+j] = d[j];
    if (a == 2) for (int i = 0; i < NI; i++) m_mask[i] = d[i];
    if (a == 3) begin
      for (int j = 0; j < NE; j++) m_mask[NI+j] = d[j];
      m_g = d[31];
    end
    if (a >= 8 && a <= 17)
      for (int k = 0; k < 4; k++)
        if ((a-8)*4+k < NSL) m_slot[(a-8)*4+k] = int'(d[8*k +: 6]);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk_i); re_i = 1; addr_i = 5'(a);
    @(posedge clk_i); #1 d = rdata_o;
    @(negedge clk_i); re_i = 0;
  endtask

  function automatic bit src_on(int s);
    bit lvl = (s < NI) ? int_src_i[s] : ext_src_i[s-NI];
    return lvl && !m_mask[s] && !m_g;
  endfunction

  function automatic bit exp_out(bit fiq);
    for (int s = 0; s < NS; s++) if (src_on(s) && m_mode[s] == fiq) return 1;
    return 0;
  endfunction

  function automatic int exp_win(bit fiq);
    int w = 63;
    for (int s = NSL-1; s >= 0; s--)
      if (m_slot[s] < NS && src_on(m_slot[s]) && m_mode[m_slot[s]] == fiq) w = m_slot[s];
    return w;
  endfunction

  task automatic full_check(string tag);
    logic [31:0] d;
    chk({tag, " irq_o R5"}, 32'(irq_o), 32'(exp_out(0)));
    chk({tag, " fiq_o R4"}, 32'(fiq_o), 32'(exp_out(1)));
    rd(4, d); chk({tag, " irq win R8"}, d, 32'(exp_win(0)));
    rd(5, d); chk({tag, " fiq win R9"}, d, 32'(exp_win(1)));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int s = 0; s < NSL; s++) m_slot[s] = (s < NS) ? s : 63;
    for (int s = 0; s < NS; s++) begin m_mode[s] = 0; m_mask[s] = 1; end
    m_g = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    rd(0, d); chk("R1 mode int", d, 0);
    rd(1, d); chk("R1 mode ext", d, 0);
    rd(2, d); chk("R1 mask int", d, 32'h007F_FFFF);
    rd(3, d); chk("R1 mask ext", d, 32'h8000_003F);
    rd(4, d); chk("R1 irq win", d, 32'h3F);
    rd(5, d); chk("R1 fiq win", d, 32'h3F);
    rd(8, d); chk("R1 slots 0-3", d, 32'h0302_0100);
    rd(15, d); chk("R1 slots 28-31", d, 32'h3F3F_3F1C);
    rd(17, d); chk("R1 slots 36-38", d, 32'h003F_3F3F);

    // R2 global mask still set: sources unmasked but blocked
    wr(2, 0); int_src_i = 23'h1;
    #1 chk("R2 gmask blocks irq", 32'(irq_o), 0);
    wr(3, 0);
    // R6 internal line is combinational
    chk("R6 internal same cycle", 32'(irq_o), 1);
    int_src_i = '0;

    // R6 external pin latency: two edges
    @(negedge clk_i); ext_src_i = 6'h1;
    @(posedge clk_i); #1 chk("R6 ext after 1 edge", 32'(irq_o), 0);
    @(posedge clk_i); #1 chk("R6 ext after 2 edges", 32'(irq_o), 1);
    // R5 level: release
    @(negedge clk_i); ext_src_i = '0;
    @(posedge clk_i); @(posedge clk_i); #1 chk("R5 released", 32'(irq_o), 0);

    // R4 route external source 24 to FIQ
    wr(1, 32'h2); ext_src_i = 6'h2;
    repeat (3) @(negedge clk_i);
    chk("R4 fiq routed", 32'(fiq_o), 1);
    chk("R4 irq not routed", 32'(irq_o), 0);
    rd(5, d); chk("R4 fiq win", d, 24);
    // R3 mask it
    wr(3, 32'h2); #1 chk("R3 masked", 32'(fiq_o), 0);
    ext_src_i = '0; wr(3, 0); wr(1, 0);

    // R7/R8 slot0=40 ignored, slot1=7, slot2=3, slot3=7 duplicate
    wr(8, 32'h0703_0728);
    rd(8, d); chk("R7 slot readback", d, 32'h0703_0728);
    int_src_i = 23'h88;
    rd(4, d); chk("R8 best slot wins", d, 7);
    // R9 source 0 occupies no slot
    int_src_i = 23'h1;
    #1 chk("R9 output high", 32'(irq_o), 1);
    rd(4, d); chk("R9 no slotted winner", d, 32'h3F);
    int_src_i = '0;

    // R10 write and read same edge
    @(negedge clk_i); we_i = 1; re_i = 1; addr_i = 5'd0; wdata_i = 32'h5;
    @(posedge clk_i); #1 chk("R10 read shows old", rdata_o, 0);
    @(negedge clk_i); we_i = 0; re_i = 0;
    m_mode[0] = 1; m_mode[2] = 1;
    rd(0, d); chk("R10 new value", d, 32'h5);

    // R2 global mask with winners present
    int_src_i = 23'h7;
    wr(3, 32'h8000_0000);
    full_check("R2 gmask");
    wr(3, 0);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 9);
      int_src_i = 23'($urandom);
      ext_src_i = 6'($urandom);
      case (sel)
        0: wr(0, $urandom);
        1: wr(1, $urandom);
        2: wr(2, $urandom & $urandom);
        3: wr(3, {($urandom_range(0, 7) == 0), 25'b0, 6'($urandom & $urandom)});
        default: begin
          logic [31:0] f;
          for (int k = 0; k < 4; k++)
            f[8*k +: 8] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 63)) : 8'($urandom_range(0, 28));
          wr(8 + $urandom_range(0, 9), f);
        end
      endcase
      repeat (3) @(negedge clk_i);
      full_check("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule